// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a fixed set of slots and reports one winning source to the processor. Each slot carries an event code equal to its slot number times 0x20. Each slot also has a 4-bit priority. Some slots have fixed priorities, some take a nibble of a writable priority register, and all the others are disabled (priority 0). The block keeps an asserted flag per slot. From these flags it chooses a winner, and it outputs the winner's event code and level together with a valid flag.

When a request rises, the winner changes by an incremental rule on the next clock edge. A new request takes over only if no winner exists or if its priority is strictly higher than the current level. When any request falls, the block starts a full rescan. The rescan walks the slots in ascending groups, one group per cycle. A slot replaces the running choice only on a strictly higher priority, so a tie goes to the lowest code. While the rescan runs, `busy` is high and `win_valid` is low. Masking against the processor's level and vector generation belong to other blocks.

The state machine has two states. `ST_IDLE` holds the winner. `ST_SCAN` walks the groups. The transitions are:
- T_HOLD: no event, stay in `ST_IDLE`.
- T_TAKE: rising edges only, apply the incremental rule and stay in `ST_IDLE`.
- T_START: any falling edge in `ST_IDLE`, go to `ST_SCAN`.
- T_STEP: next group.
- T_RESTART: any rising or falling edge while in `ST_SCAN`, start the scan again at group 0.
- T_DONE: last group merged, commit the result and return to `ST_IDLE`.

Top module: `prio_intc`

## Requirements
- R1: The register port holds ten 32-bit registers at addresses 0..9. Their reset values are 0 at addresses 0, 1 and 2, 0x0000da74 at 3, 0xf3ff7fff at 4, 0x00ffffff at 5, and 0x33333333 at each of 6..9. A write lands on the next edge and `reg_rdata` reads the addressed register combinationally. Addresses 10..15 read 0 and ignore writes.
- R2: `win_code` equals the winning slot number times 0x20 (slot in bits 11..5, bits 4..0 zero).
- R3: The timer slots 32, 33 and 34 (codes 0x400, 0x420, 0x440) take their priorities from bits 15..12, 11..8 and 7..4 of register 0. Bits 3..0 of register 0 are stored but drive no priority.
- R4: The external request slots 16..30 (codes 0x200..0x3C0) have fixed priorities: slot 16 has 15, and each later slot has one less.
- R5: The serial group, slots 56..59 (codes 0x700..0x760), all share the priority in bits 19..16 of register 8.
- R6: Every other slot has priority 0, never wins, and a valid winner never reports level 0.
- R7: When requests only rise, the winner is updated on the first clock edge that sees the rise. A rising slot with non-zero priority takes over if no winner exists or if its priority is strictly greater than the current level. On a tie the old winner stays.
- R8: Any falling request starts a rescan. `busy` is high and `win_valid` low for exactly NSLOT/LANES cycles. The rescan then commits the highest priority among the asserted slots, and a tie goes to the lowest code.
- R9: A rising or falling request during a rescan restarts it from group 0, so the committed result reflects every flag.
- R10: A priority register write changes neither the asserted flags nor the reported winner and level. The next rescan uses the new priorities.
- R11: With no slot asserted and no scan running, `win_valid` is 0 and `win_code` and `win_level` read 0. They also read 0 whenever `win_valid` is low.
- R12: A rise and a fall in the same cycle produce a full rescan that includes the newly risen slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NSLOT | Level request per slot |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| win_code | output | 12 | Winning event code |
| win_level | output | 4 | Winning priority level |
| win_valid | output | 1 | Winner present and outputs stable |
| busy | output | 1 | Rescan in progress |

## Verification
The incremental update on a rising request and the full rescan on a falling request can fall in the same clock cycle. A rescan can also be interrupted by a new event. The bench provokes both cases directly: it lowers one request in the same cycle that it raises another, and it raises a request while `busy` is high. Random event mixes add further cases of both kinds. The result is judged against a bench model that clears and sets the flags first and then runs a full ascending scan with strict-greater replacement.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int AW        = 4;
    localparam int DW        = 32;
    localparam int NREG      = 10;
    localparam int RA_TMR    = 0;
    localparam int RA_XPRI2  = 8;
    localparam int TMR_SLOT0 = 32;
    localparam int TMR_COUNT = 3;
    localparam int IRQ_SLOT0 = 16;
    localparam int IRQ_COUNT = 15;
    localparam int SER_SLOT0 = 56;
    localparam int SER_COUNT = 4;

    typedef enum logic {ST_IDLE, ST_SCAN} scan_state_e;

    function automatic logic [DW-1:0] reg_reset(input int i);
        case (i)
            3:             return 32'h0000_da74;
            4:             return 32'hf3ff_7fff;
            5:             return 32'h00ff_ffff;
            6, 7, 8, 9:    return 32'h3333_3333;
            default:       return '0;
        endcase
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [11:0]   tmr_nib,
    output logic [3:0]    ser_nib
);
    logic [DW-1:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= reg_reset(i);
            else if (we && addr == AW'(i))
                q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (addr == AW'(i)) rdata = q[i];
    end

    assign tmr_nib = q[RA_TMR][15:4];
    assign ser_nib = q[RA_XPRI2][19:16];

    AST_SER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(RA_XPRI2)) |=> ser_nib == $past(wdata[19:16])); // R5
endmodule

// File: rtl/pic_prio_map.sv
module pic_prio_map
    import pic_pkg::*;
#(
    parameter int NSLOT = 128
) (
    input  logic [11:0]        tmr_nib,
    input  logic [3:0]         ser_nib,
    output logic [NSLOT*4-1:0] prio_flat
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s >= TMR_SLOT0 && s < TMR_SLOT0 + TMR_COUNT) begin : g_tmr
            assign prio_flat[s*4 +: 4] = tmr_nib[11 - 4*(s - TMR_SLOT0) -: 4];
        end else if (s >= IRQ_SLOT0 && s < IRQ_SLOT0 + IRQ_COUNT) begin : g_irq
            assign prio_flat[s*4 +: 4] = 4'(15 - (s - IRQ_SLOT0));
        end else if (s >= SER_SLOT0 && s < SER_SLOT0 + SER_COUNT) begin : g_ser
            assign prio_flat[s*4 +: 4] = ser_nib;
        end else begin : g_off
            assign prio_flat[s*4 +: 4] = 4'h0;
        end
    end
endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   flag,
    input  logic [N*4-1:0] prio,
    output logic           found,
    output logic [IW-1:0]  idx,
    output logic [3:0]     lvl
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        lvl   = 4'h0;
        for (int i = 0; i < N; i++) begin
            if (flag[i] && prio[i*4 +: 4] > lvl) begin
                found = 1'b1;
                idx   = IW'(i);
                lvl   = prio[i*4 +: 4];
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
#(
    parameter int NSLOT = 128,
    parameter int LANES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] req,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [11:0]      win_code,
    output logic [3:0]       win_level,
    output logic             win_valid,
    output logic             busy
);
    localparam int NGRP = NSLOT / LANES;
    localparam int SW   = $clog2(NSLOT);
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CW   = 12;

    scan_state_e state_q, state_d;

    logic [NSLOT-1:0]   flag_q, rise, fall;
    logic               ev_rise, ev_fall;
    logic [11:0]        tmr_nib;
    logic [3:0]         ser_nib;
    logic [NSLOT*4-1:0] prio_flat;
    logic               rp_found;
    logic [SW-1:0]      rp_idx;
    logic [3:0]         rp_lvl;
    logic [LANES-1:0]   g_flag;
    logic [LANES*4-1:0] g_prio;
    logic               gp_found;
    logic [LW-1:0]      gp_idx;
    logic [3:0]         gp_lvl;
    logic [GW-1:0]      ptr_q;
    logic [SW-1:0]      cand_idx, m_idx, idx_q;
    logic [3:0]         cand_lvl, m_lvl, lvl_q;
    logic               has_q, last_grp;
    logic [GW:0]        scan_len;

    pic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .tmr_nib(tmr_nib), .ser_nib(ser_nib)
    );

    pic_prio_map #(.NSLOT(NSLOT)) u_map (
        .tmr_nib(tmr_nib), .ser_nib(ser_nib), .prio_flat(prio_flat)
    );

    assign rise    = req & ~flag_q;
    assign fall    = ~req & flag_q;
    assign ev_rise = |rise;
    assign ev_fall = |fall;

    pic_pick #(.N(NSLOT), .IW(SW)) u_rise (
        .flag(rise), .prio(prio_flat), .found(rp_found), .idx(rp_idx), .lvl(rp_lvl)
    );

    always_comb begin
        g_flag = flag_q[int'(ptr_q)*LANES +: LANES];
        g_prio = prio_flat[int'(ptr_q)*LANES*4 +: LANES*4];
    end

    pic_pick #(.N(LANES), .IW(LW)) u_grp (
        .flag(g_flag), .prio(g_prio), .found(gp_found), .idx(gp_idx), .lvl(gp_lvl)
    );

    assign last_grp = (ptr_q == GW'(NGRP - 1));

    always_comb begin
        m_idx = cand_idx;
        m_lvl = cand_lvl;
        if (gp_found && gp_lvl > cand_lvl) begin
            m_idx = SW'(int'(ptr_q) * LANES) + SW'(gp_idx);
            m_lvl = gp_lvl;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ev_fall) state_d = ST_SCAN;                  // T_START
            ST_SCAN: if (!(ev_rise || ev_fall) && last_grp)
                         state_d = ST_IDLE;                            // T_DONE
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q   <= '0;
            ptr_q    <= '0;
            cand_idx <= '0;
            cand_lvl <= '0;
            idx_q    <= '0;
            lvl_q    <= '0;
            has_q    <= 1'b0;
        end else begin
            flag_q <= req;
            unique case (state_q)
                ST_IDLE: begin
                    if (ev_fall) begin                                 // T_START
                        ptr_q    <= '0;
                        cand_idx <= '0;
                        cand_lvl <= '0;
                        has_q    <= 1'b0;
                    end else if (rp_found && (!has_q || rp_lvl > lvl_q)) begin // T_TAKE
                        has_q <= 1'b1;
                        idx_q <= rp_idx;
                        lvl_q <= rp_lvl;
                    end
                end
                ST_SCAN: begin
                    if (ev_rise || ev_fall) begin                      // T_RESTART
                        ptr_q    <= '0;
                        cand_idx <= '0;
                        cand_lvl <= '0;
                    end else if (last_grp) begin                       // T_DONE
                        has_q <= (m_lvl != 4'h0);
                        idx_q <= m_idx;
                        lvl_q <= m_lvl;
                    end else begin                                     // T_STEP
                        ptr_q    <= ptr_q + 1'b1;
                        cand_idx <= m_idx;
                        cand_lvl <= m_lvl;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_SCAN);
        win_valid = has_q && !busy;
        win_code  = win_valid ? CW'({idx_q, 5'b0}) : '0;
        win_level = win_valid ? lvl_q : 4'h0;
    end

    // scan length monitor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   scan_len <= '0;
        else if (!busy || ev_rise || ev_fall)         scan_len <= '0;
        else                                          scan_len <= scan_len + 1'b1;
    end

    AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> scan_len < (GW+1)'(NGRP)); // R8
    AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !busy); // R8
    AST_WIN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> flag_q[idx_q]); // R7
    AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> win_level != 4'h0); // R6
    AST_QUIET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0 && !busy) |-> !win_valid); // R11
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    localparam int NSLOT = 128;
    localparam int LANES = 16;
    localparam int NGRP  = NSLOT / LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSLOT-1:0] req = '0;
    logic             reg_we = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [11:0]      win_code;
    logic [3:0]       win_level;
    logic             win_valid;
    logic             busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0]      m_reg [10];
    logic [NSLOT-1:0] m_flag = '0;
    logic             m_has = 1'b0;
    int               m_idx = 0;
    logic [3:0]       m_lvl = '0;
    int               last_busy = 0;

    prio_intc #(.NSLOT(NSLOT), .LANES(LANES)) u_prio_intc (
        .clk(clk), .rst_n(rst_n), .req(req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_code(win_code),
        .win_level(win_level), .win_valid(win_valid), .busy(busy)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] rst_val(input int i);
        if (i == 3) return 32'h0000_da74;
        if (i == 4) return 32'hf3ff_7fff;
        if (i == 5) return 32'h00ff_ffff;
        if (i >= 6 && i <= 9) return 32'h3333_3333;
        return 32'h0;
    endfunction

    function automatic logic [3:0] m_prio(input int s);
        if (s >= 32 && s <= 34) return m_reg[0][15 - 4*(s-32) -: 4];
        if (s >= 16 && s <= 30) return 4'(15 - (s - 16));
        if (s >= 56 && s <= 59) return m_reg[8][19:16];
        return 4'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic m_rescan();
        m_has = 1'b0; m_lvl = '0; m_idx = 0;
        for (int s = 0; s < NSLOT; s++)
            if (m_flag[s] && m_prio(s) > m_lvl) begin
                m_has = 1'b1; m_idx = s; m_lvl = m_prio(s);
            end
    endtask

    task automatic m_event(input logic [NSLOT-1:0] nv);
        logic [NSLOT-1:0] ri, fa;
        ri = nv & ~m_flag;
        fa = m_flag & ~nv;
        m_flag = nv;
        if (fa != '0) m_rescan();
        else
            for (int s = 0; s < NSLOT; s++)
                if (ri[s] && m_prio(s) != 0 && (!m_has || m_prio(s) > m_lvl)) begin
                    m_has = 1'b1; m_idx = s; m_lvl = m_prio(s);
                end
    endtask

    task automatic settle();
        last_busy = 0;
        @(negedge clk);
        while (busy && last_busy < 200) begin
            last_busy++;
            @(negedge clk);
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " valid"}, 32'(win_valid), 32'(m_has));
        check({tag, " R2 code"}, 32'(win_code), m_has ? 32'(m_idx * 32) : 32'h0);
        check({tag, " level"}, 32'(win_level), m_has ? 32'(m_lvl) : 32'h0);
    endtask

    task automatic apply(input logic [NSLOT-1:0] nv, input string tag);
        req = nv;
        m_event(nv);
        @(posedge clk);
        settle();
        compare(tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a < 10) m_reg[a] = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        logic [NSLOT-1:0] v;
        void'($urandom(32'h1F2E3D));
        for (int i = 0; i < 10; i++) m_reg[i] = rst_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11 reset state
        for (int i = 0; i < 16; i++) begin
            reg_addr = 4'(i);
            #1;
            check("R1 reset read", reg_rdata, (i < 10) ? rst_val(i) : 32'h0);
        end
        check("R11 reset valid", 32'(win_valid), 0);
        check("R11 reset code", 32'(win_code), 0);
        check("R8 reset busy", 32'(busy), 0);

        // R1 unmapped write ignored, mapped write read back
        wr(4'd12, 32'hdead_beef);
        reg_addr = 4'd12; #1;
        check("R1 unmapped read", reg_rdata, 32'h0);
        wr(4'd4, 32'h1234_5678);
        reg_addr = 4'd4; #1;
        check("R1 write readback", reg_rdata, 32'h1234_5678);

        // R5 / R7 ties keep the old winner; R6 disabled slot
        v = '0; v[57] = 1'b1;
        apply(v, "R5 serial prio");
        check("R5 serial level", 32'(win_level), 3);
        check("R7 one-cycle take", 32'(last_busy), 0);
        v[56] = 1'b1;
        apply(v, "R7 tie keeps old");
        check("R7 tie code", 32'(win_code), 32'h720);
        v[100] = 1'b1;
        apply(v, "R6 disabled slot");
        check("R6 disabled never wins", 32'(win_code), 32'h720);
        v[100] = 1'b0;
        apply(v, "R8 rescan tie");
        check("R8 tie lowest code", 32'(win_code), 32'h700);
        check("R8 busy cycles", 32'(last_busy), NGRP);

        // R4 fixed priority
        v[16] = 1'b1;
        apply(v, "R4 irq0");
        check("R4 irq0 level", 32'(win_level), 15);

        // R3 timer nibbles
        wr(4'd0, 32'h0000_a9b0);
        v[33] = 1'b1;
        apply(v, "R3 timer1 lower");
        v[16] = 1'b0;
        apply(v, "R3 rescan timer1");
        check("R3 timer1 level", 32'(win_level), 9);
        v[34] = 1'b1;
        apply(v, "R3 timer2 takes");
        check("R3 timer2 code", 32'(win_code), 32'h440);

        // R10 rewrite leaves winner, next rescan uses new value
        wr(4'd0, 32'h0000_a910);
        @(negedge clk);
        check("R10 winner stale level", 32'(win_level), 11);
        check("R10 winner stale valid", 32'(win_valid), 1);
        v[57] = 1'b0;
        apply(v, "R10 rescan new prio");
        check("R10 new winner", 32'(win_code), 32'h420);

        // R12 rise and fall together
        v[33] = 1'b0; v[16] = 1'b1;
        apply(v, "R12 same cycle");
        check("R12 winner", 32'(win_code), 32'h200);

        // R9 restart during scan
        v[16] = 1'b0;
        req = v; m_event(v);
        @(posedge clk);
        @(negedge clk);
        check("R9 busy during scan", 32'(busy), 1);
        v[32] = 1'b1;
        req = v; m_event(v);
        @(posedge clk);
        settle();
        compare("R9 restart");
        check("R9 restart winner", 32'(win_code), 32'h400);

        // R11 all clear
        apply('0, "R11 all clear");
        check("R11 clear code", 32'(win_code), 0);

        // random mix
        v = '0;
        for (int it = 0; it < 400; it++) begin
            int k;
            int s;
            k = $urandom_range(0, 9);
            s = (k < 2) ? $urandom_range(0, NSLOT-1)
                        : (int'($urandom_range(0, 3)) == 0 ? 56 + $urandom_range(0, 3)
                        : 16 + $urandom_range(0, 19));
            if (k <= 3) begin
                v[s] = 1'b1;
                apply(v, "R7 random rise");
            end else if (k <= 6) begin
                v[s] = 1'b0;
                v[$urandom_range(0, NSLOT-1)] = 1'b0;
                apply(v, "R8 random fall");
            end else if (k == 7) begin
                v[s] = ~v[s];
                v[$urandom_range(16, 40)] = ~v[s];
                apply(v, "R12 random mix");
            end else begin
                wr((k == 8) ? 4'd0 : 4'd8, $urandom());
                @(negedge clk);
                compare("R10 random write");
            end
        end
        finish_run();
    end
endmodule